// File: doc/BRIEF.md
# Paced Toggle-Rate Stress Shift Chain

This block is a long internal register chain that exercises logic at a switching rate chosen by configuration. A 4-bit setting selects one of 16 stress patterns. Three bits set the pacing, which is how often the chain may advance. The fourth bit sets the data shape fed into the head of the chain. A pacer issues one shift-enable pulse every 2^p clocks. That pulse reaches the chain through several identical register copies, and each copy drives a bounded segment of cells. With the toggling data shape, pace 0 makes every cell switch on every clock (100%). Pace 3 gives the usual 12.5% simultaneous-switching load.

A checker watches the tail of the chain. It keeps its own copy of the pattern source and compares the tail with the bit that entered the chain one chain-length of shifts earlier. The checker stays silent until the chain has been refilled after reset. After that, any mismatch is latched as a sticky error. A slow monitor output blinks while the chain is healthy, so a lamp or a slow tester pin can show that the block is alive. On failure the monitor drops low and stays low.

The external reset is asserted asynchronously and released synchronously into the clock domain. The configuration is captured while reset is held, so the whole run uses one pattern. The self-check only sees the tail stream. A fault that does not change that stream goes undetected.

Top module: `toggle_stress_chain`

## Requirements
- R1: The reset is released through a two-stage synchronizer. Counting rising edges from the first one that samples rst_n high, the first chain shift happens on edge 4. While rst_n is low, err_o and mon_o are 0.
- R2: cfg_i is captured on every clock edge while the synchronized reset is active and held after that. Changing cfg_i after release has no effect until the next reset.
- R3: With p = cfg_i[2:0], the chain shifts on edges 4, 4+2^p, 4+2*2^p, and so on. On all other edges no chain cell changes.
- R4: With cfg_i[3]=0, the head is fed 0,1,0,1,... one value per shift. With cfg_i[3]=1 it is fed 0,0,1,1,0,0,1,1,... Each sequence restarts at its first value after every reset.
- R5: A bit fed into the head appears on tail_o after CHAIN_LEN shifts, counting the shift that loads it. Between shifts tail_o holds.
- R6: The shift enable is carried by ceil(CHAIN_LEN/SEG_FANOUT) register copies that are equal on every cycle. Copy j drives cells j*SEG_FANOUT to j*SEG_FANOUT+SEG_FANOUT-1.
- R7: Until CHAIN_LEN shifts have taken place since reset, no tail value can set the error, whatever the chain held before.
- R8: Once the chain is flushed, a cycle in which tail_o differs from the expected pattern bit sets err_o on the next edge. err_o then stays 1 until reset.
- R9: While err_o is 0, mon_o toggles once every 2^ALIVE_W clocks. The first toggle is on edge 2^ALIVE_W+2 after release. From the edge after err_o rises, mon_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 4 | Bit 3: data shape (0 toggling, 1 paired). Bits 2:0: pacing exponent |
| mon_o | output | 1 | Pass/fail monitor: blinks on pass, low on fail |
| tail_o | output | 1 | Last cell of the chain |
| err_o | output | 1 | Sticky mismatch flag |

## Verification
The bound assertions check on every cycle that the enable copies agree, that the chain tail holds when no enable is active, that the captured configuration stays frozen after release, and that the error flag is sticky. They also check that the flag cannot rise before the flush completes, and that the monitor moves only on a counter wrap and falls after a failure. Only the bench scenarios can show that the tail stream carries exactly the configured pattern at the configured pace for several settings. The same holds for the claim that a late configuration change is ignored, and that a corrupted head bit travels the full chain, is flagged when it reaches the tail, and is cleared by the next reset.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // Pacing exponent width; one more bit selects the data shape.
  localparam int unsigned PACE_W = 3;
  localparam int unsigned CFG_W  = PACE_W + 1;

  typedef struct packed {
    logic              alt_mode;
    logic [PACE_W-1:0] pace;
  } stress_cfg_t;

  typedef logic [1:0] pat_phase_t;

  // Head data for a given shift index: toggling (bit 0) or paired (bit 1).
  function automatic logic pattern_bit(input logic alt_mode, input pat_phase_t ph);
    return alt_mode ? ph[1] : ph[0];
  endfunction

endpackage

// File: rtl/tsc_rst_sync.sv
module tsc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/tsc_pacer.sv
module tsc_pacer #(
  parameter int unsigned PACE_W = 3,
  parameter int unsigned NUM_EN = 1
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [PACE_W-1:0] pace_i,
  output logic [NUM_EN-1:0] en_o
);

  // Counter just wide enough for the slowest pace (2^(2^PACE_W - 1)).
  localparam int unsigned CNT_W = (1 << PACE_W) - 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d, mask;
  logic              fire;
  logic [NUM_EN-1:0] en_q, en_d;

  always_comb begin
    mask  = ~({CNT_W{1'b1}} << pace_i);
    fire  = ((cnt_q & mask) == '0);
    cnt_d = cnt_q + 1'b1;
    en_d  = {NUM_EN{fire}};
  end

  // Replicated enable registers: each copy feeds one bounded chain segment.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q <= '0;
      en_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/tsc_patgen.sv
module tsc_patgen
  import tsc_pkg::*;
(
  input  logic clk,
  input  logic srst_n,
  input  logic alt_mode_i,
  input  logic step_i,
  output logic head_o
);

  pat_phase_t phase_q, phase_d;

  always_comb begin
    phase_d = step_i ? pat_phase_t'(phase_q + 2'd1) : phase_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  assign head_o = pattern_bit(alt_mode_i, phase_q);

endmodule

// File: rtl/tsc_chain.sv
module tsc_chain #(
  parameter int unsigned LEN     = 707,
  parameter int unsigned FANOUT  = 16,
  parameter int unsigned NUM_EN  = (LEN + FANOUT - 1) / FANOUT
) (
  input  logic              clk,
  input  logic [NUM_EN-1:0] en_i,
  input  logic              head_i,
  output logic              tail_o
);

  logic [LEN-1:0] stage_q, stage_d, feed, en_bit;

  // Map each cell to the enable copy of its segment.
  for (genvar i = 0; i < LEN; i++) begin : g_cell_en
    assign en_bit[i] = en_i[i / FANOUT];
  end

  always_comb begin
    feed    = {stage_q[LEN-2:0], head_i};
    stage_d = (en_bit & feed) | (~en_bit & stage_q);
  end

  // Data cells carry no reset; the checker waits for a full flush instead.
  always_ff @(posedge clk) begin
    stage_q <= stage_d;
  end

  assign tail_o = stage_q[LEN-1];

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
  import tsc_pkg::*;
#(
  parameter int unsigned LEN     = 707,
  parameter int unsigned ALIVE_W = 20
) (
  input  logic clk,
  input  logic srst_n,
  input  logic step_i,
  input  logic alt_mode_i,
  input  logic tail_i,
  output logic err_o,
  output logic mon_o,
  output logic flushed_o,
  output logic alive_wrap_o
);

  localparam int unsigned    FL_W    = $clog2(LEN + 1);
  localparam logic [FL_W-1:0] FULL   = FL_W'(LEN);
  localparam pat_phase_t      LEN_MOD = pat_phase_t'(LEN % 4);

  pat_phase_t         ref_phase_q, ref_phase_d;
  logic [FL_W-1:0]    fl_q, fl_d;
  logic [ALIVE_W-1:0] alive_q, alive_d;
  logic               err_q, err_d, mon_q, mon_d;
  logic               flushed, exp_bit, mismatch, wrap;

  always_comb begin
    // Local pattern copy, read one chain length of shifts back.
    ref_phase_d = step_i ? pat_phase_t'(ref_phase_q + 2'd1) : ref_phase_q;
    flushed     = (fl_q == FULL);
    fl_d        = (step_i && !flushed) ? fl_q + 1'b1 : fl_q;
    exp_bit     = pattern_bit(alt_mode_i, pat_phase_t'(ref_phase_q - LEN_MOD));
    mismatch    = flushed && (tail_i != exp_bit);
    err_d       = err_q | mismatch;
    alive_d     = alive_q + 1'b1;
    wrap        = &alive_q;
    mon_d       = err_q ? 1'b0 : (wrap ? ~mon_q : mon_q);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ref_phase_q <= '0;
      fl_q        <= '0;
      alive_q     <= '0;
      err_q       <= 1'b0;
      mon_q       <= 1'b0;
    end else begin
      ref_phase_q <= ref_phase_d;
      fl_q        <= fl_d;
      alive_q     <= alive_d;
      err_q       <= err_d;
      mon_q       <= mon_d;
    end
  end

  assign err_o        = err_q;
  assign mon_o        = mon_q;
  assign flushed_o    = flushed;
  assign alive_wrap_o = wrap;

endmodule

// File: rtl/toggle_stress_chain.sv
module toggle_stress_chain
  import tsc_pkg::*;
#(
  parameter int unsigned CHAIN_LEN  = 707,
  parameter int unsigned SEG_FANOUT = 16,
  parameter int unsigned ALIVE_W    = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             mon_o,
  output logic             tail_o,
  output logic             err_o
);

  localparam int unsigned NUM_EN = (CHAIN_LEN + SEG_FANOUT - 1) / SEG_FANOUT;

  logic              srst_n;
  stress_cfg_t       cfg_q, cfg_d;
  logic [NUM_EN-1:0] en_w;
  logic              head_w;
  logic              flushed_w, alive_wrap_w;

  tsc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // Configuration follows the pins while reset is held, then freezes.
  always_comb begin
    cfg_d = srst_n ? cfg_q : stress_cfg_t'(cfg_i);
  end

  always_ff @(posedge clk) begin
    cfg_q <= cfg_d;
  end

  tsc_pacer #(.PACE_W(PACE_W), .NUM_EN(NUM_EN)) u_pacer (
    .clk    (clk),
    .srst_n (srst_n),
    .pace_i (cfg_q.pace),
    .en_o   (en_w)
  );

  tsc_patgen u_patgen (
    .clk        (clk),
    .srst_n     (srst_n),
    .alt_mode_i (cfg_q.alt_mode),
    .step_i     (en_w[0]),
    .head_o     (head_w)
  );

  tsc_chain #(.LEN(CHAIN_LEN), .FANOUT(SEG_FANOUT), .NUM_EN(NUM_EN)) u_chain (
    .clk    (clk),
    .en_i   (en_w),
    .head_i (head_w),
    .tail_o (tail_o)
  );

  tsc_checker #(.LEN(CHAIN_LEN), .ALIVE_W(ALIVE_W)) u_checker (
    .clk          (clk),
    .srst_n       (srst_n),
    .step_i       (en_w[0]),
    .alt_mode_i   (cfg_q.alt_mode),
    .tail_i       (tail_o),
    .err_o        (err_o),
    .mon_o        (mon_o),
    .flushed_o    (flushed_w),
    .alive_wrap_o (alive_wrap_w)
  );

endmodule

// File: rtl/tsc_sva.sv
module tsc_sva #(
  parameter int unsigned NUM_EN = 1,
  parameter int unsigned CFG_W  = 4
) (
  input logic              clk,
  input logic              srst_n,
  input logic [NUM_EN-1:0] en_q,
  input logic [CFG_W-1:0]  cfg_q,
  input logic              err_o,
  input logic              mon_o,
  input logic              tail_o,
  input logic              flushed,
  input logic              alive_wrap
);

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!srst_n)
    srst_n |=> $stable(cfg_q)); // R2

  AST_TAIL_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    (en_q == '0) |=> $stable(tail_o)); // R3

  AST_EN_COPIES_AGREE: assert property (@(posedge clk) disable iff (!srst_n)
    (en_q == '0) || (en_q == '1)); // R6

  AST_QUIET_BEFORE_FLUSH: assert property (@(posedge clk) disable iff (!srst_n)
    (!flushed && !err_o) |=> !err_o); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    err_o |=> err_o); // R8

  AST_MON_LOW_ON_FAIL: assert property (@(posedge clk) disable iff (!srst_n)
    err_o |=> !mon_o); // R9

  AST_MON_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!srst_n)
    (!alive_wrap && !err_o) |=> $stable(mon_o)); // R9

endmodule

bind toggle_stress_chain tsc_sva #(.NUM_EN(NUM_EN), .CFG_W(tsc_pkg::CFG_W)) u_sva (
  .clk        (clk),
  .srst_n     (srst_n),
  .en_q       (en_w),
  .cfg_q      (cfg_q),
  .err_o      (err_o),
  .mon_o      (mon_o),
  .tail_o     (tail_o),
  .flushed    (flushed_w),
  .alive_wrap (alive_wrap_w)
);

// File: tb/toggle_stress_chain_tb.sv
module toggle_stress_chain_tb;

  localparam int LEN = 40;
  localparam int FAN = 16;
  localparam int AW  = 6;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cfg_i;
  logic       mon_o, tail_o, err_o;

  always #5 clk = ~clk;

  toggle_stress_chain #(.CHAIN_LEN(LEN), .SEG_FANOUT(FAN), .ALIVE_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i),
    .mon_o(mon_o), .tail_o(tail_o), .err_o(err_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;

  // Behavioural reference state
  int     m = 0, phase = 0, shifts = 0, alive = 0;
  bit [3:0] mcfg;
  bit     merr = 0, mmon = 0, inj = 0, inj_val = 0, chk_on = 0;
  bit     q[$];
  bit     s_do, s_fl, s_ideal, s_tail, s_head;

  function automatic bit pat(bit alt, int ph);
    return alt ? ph[1] : ph[0];
  endfunction

  function automatic bit shift_at(int e, bit [3:0] c);
    int per = 1 << c[2:0];
    return (e >= 4) && (((e - 4) % per) == 0);
  endfunction

  task automatic check(string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b cycle=%0d", what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = 0; phase = 0; shifts = 0; alive = 0; merr = 0; mmon = 0;
      mcfg = cfg_i;
    end else begin
      m++;
      if (m <= 2) begin
        mcfg = cfg_i;
      end else begin
        s_do    = shift_at(m, mcfg);
        s_fl    = (shifts >= LEN);
        s_ideal = pat(mcfg[3], phase - LEN);
        s_tail  = (q.size() == LEN) ? q[LEN-1] : 1'b0;
        mmon    = merr ? 1'b0 : ((alive == (1 << AW) - 1) ? ~mmon : mmon);
        merr    = merr | (s_fl && (s_tail != s_ideal));
        alive   = (alive + 1) % (1 << AW);
        if (s_do) begin
          s_head = inj ? inj_val : pat(mcfg[3], phase);
          q.push_front(s_head);
          if (q.size() > LEN) void'(q.pop_back());
          phase++;
          shifts++;
        end
      end
    end
  end

  // Outputs sampled mid-cycle, away from the active edge.
  always @(negedge clk) begin
    if (chk_on) begin
      check("R8 err_o", err_o, merr);
      check("R9 mon_o", mon_o, mmon);
      if (q.size() == LEN) check("R3 R4 R5 R6 tail_o", tail_o, q[LEN-1]);
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic do_reset(logic [3:0] c);
    tick(1);
    rst_n = 1'b0;
    cfg_i = c;
    tick(2);
    check("R1 err_o in reset", err_o, 1'b0);
    check("R1 mon_o in reset", mon_o, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(logic [3:0] c);
    do_reset(c);
    tick(LEN * (1 << c[2:0]) * 2 + 200);
    check("R7 R8 no false error", err_o, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_i = 4'h0;
    tick(3);
    chk_on = 1'b1;
    check("R1 err_o at start", err_o, 1'b0);
    check("R1 mon_o at start", mon_o, 1'b0);

    // R3 R4: several pacings and both data shapes
    run_cfg(4'h0);
    run_cfg(4'h1);
    run_cfg(4'h3);
    run_cfg(4'h8);
    run_cfg(4'hA);
    run_cfg(4'hF);
    run_cfg(4'h7);

    // R2: late configuration change is ignored
    do_reset(4'h3);
    tick(LEN * 8);
    cfg_i = 4'hA;
    tick(LEN * 16);
    check("R2 cfg change ignored", err_o, 1'b0);

    // R8 R9: corrupt one head bit after the flush
    do_reset(4'h2);
    tick(LEN * 4 * 2);
    while (!shift_at(m + 1, mcfg)) tick(1);
    inj_val = ~pat(mcfg[3], phase);
    inj = 1'b1;
    if (inj_val) force u_dut.head_w = 1'b1;
    else         force u_dut.head_w = 1'b0;
    tick(1);
    release u_dut.head_w;
    inj = 1'b0;
    tick(LEN * 4 + 50);
    check("R8 error latched", err_o, 1'b1);
    check("R9 monitor low on fail", mon_o, 1'b0);
    tick(300);
    check("R8 error sticky", err_o, 1'b1);

    // R8: reset clears the error
    do_reset(4'h0);
    tick(3);
    check("R8 cleared by reset", err_o, 1'b0);
    tick(LEN * 2 + 100);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule